// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control state machine for a 32-bit RISC datapath that has no pipeline. Each instruction runs through a chain of states, one state per clock. Every instruction starts with a shared fetch state and a shared decode state. After decode, each instruction class takes its own route. Loads use five cycles. Register-register operations, OR-immediate and stores use four. Branch-on-equal and jump use three. An opcode the block does not recognise returns to fetch after two cycles.

The register file, the ALU, the memory and the holding registers (instruction, operands A and B, ALU result, memory data, branch target) are all outside the block. The sequencer reads the opcode and function field from the instruction register. It reads the ALU zero flag during the branch state. It drives the enables and selects that steer the datapath. Decode always adds the shifted branch offset to the incremented PC and stores that sum as a candidate target, before the opcode is known. The block also reports its current state as a one-hot vector and the number of cycles the last finished instruction used.

State routes. The names are the output states, with their one-hot bit index:
- FETCH(0) → DECODE(1)
- DECODE → EXE_R(2) → WB_R(7) → FETCH
- DECODE → EXE_I(3) → WB_I(8) → FETCH
- DECODE → ADDR(4) → MRD(5) → WB_LD(9) → FETCH
- ADDR → MWR(6) → FETCH
- DECODE → BEQ(10) → FETCH
- DECODE → JMP(11) → FETCH
- DECODE → FETCH (illegal)

Top module: `mcs_ctl_seq`

## Requirements
- R1: Synchronous active-high `rst` forces FETCH (`state_oh` = 12'h001) and `cpi_last` = 0. While `rst` is high, `ir_wr`, `pc_wr`, `rf_wr`, `mem_rd`, `mem_wr`, `ab_wr`, `tgt_wr` and `illegal` are all 0.
- R2: In FETCH the block asserts `mem_rd`, `ir_wr` and `pc_wr`, with `pc_src`=0 (sequential), `mem_addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4) and `alu_op`=0 (add). The next state is always DECODE.
- R3: In DECODE the block asserts `ab_wr` and `tgt_wr`, with `alu_a_sel`=0, `alu_b_sel`=3 (sign-extended immediate shifted left by two) and `alu_op`=0. This happens for every opcode.
- R4: Opcode 6'h00 with a function field in {6'h20 add, 6'h22 sub, 6'h24 and, 6'h25 or, 6'h2A slt} runs FETCH, DECODE, EXE_R, WB_R. EXE_R sets `alu_a_sel`=1 (A) and `alu_b_sel`=0 (B), and sets `alu_op` to 0, 1, 2, 3 or 4 in that same order. WB_R sets `rf_wr`=1 and `rf_dst`=1 (rd).
- R5: Opcode 6'h0D (OR-immediate) runs FETCH, DECODE, EXE_I, WB_I. EXE_I sets `alu_a_sel`=1, `alu_b_sel`=4 (zero-extended immediate) and `alu_op`=3. WB_I sets `rf_wr`=1 and `rf_dst`=0 (rt).
- R6: Opcode 6'h23 (load) runs FETCH, DECODE, ADDR, MRD, WB_LD. ADDR sets `alu_a_sel`=1, `alu_b_sel`=2 (sign-extended immediate) and `alu_op`=0. MRD sets `mem_rd`=1 and `mem_addr_sel`=1 (ALU result). WB_LD sets `rf_wr`=1, `rf_dst`=0 and `mem_to_reg`=1.
- R7: Opcode 6'h2B (store) runs FETCH, DECODE, ADDR, MWR. MWR sets `mem_wr`=1 and `mem_addr_sel`=1. A store never asserts `rf_wr`.
- R8: Opcode 6'h04 (branch-on-equal) runs FETCH, DECODE, BEQ. BEQ sets `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=1 and `pc_src`=1 (stored target). In BEQ, `pc_wr` equals `alu_zero` in the same cycle.
- R9: Opcode 6'h02 (jump) runs FETCH, DECODE, JMP. JMP sets `pc_wr`=1 and `pc_src`=2 (jump address).
- R10: Any other opcode, or opcode 6'h00 with a function field outside R4's set, raises `illegal` for the DECODE cycle only. The block then returns to FETCH and writes nothing else.
- R11: `state_oh` has exactly one bit set, at the state index given in the routes above. Any select or enable that a state does not name is 0.
- R12: In the first FETCH cycle after an instruction ends, `cpi_last` holds the number of cycles that instruction used: 5, 4, 3 or 2.
- R13: `mem_rd` and `mem_wr` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | PC load |
| pc_src | output | 2 | PC source: 0 ALU, 1 stored target, 2 jump address |
| rf_wr | output | 1 | Register file write |
| rf_dst | output | 1 | Destination: 0 rt, 1 rd |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 A |
| alu_b_sel | output | 3 | ALU B input: 0 B, 1 four, 2 sext, 3 sext<<2, 4 zext |
| alu_op | output | 3 | 0 add, 1 sub, 2 and, 3 or, 4 slt |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result |
| mem_to_reg | output | 1 | Write-back data: 0 ALU result, 1 memory data |
| ab_wr | output | 1 | Operand registers A/B load |
| tgt_wr | output | 1 | Candidate branch target load |
| illegal | output | 1 | Unrecognised instruction, DECODE cycle only |
| state_oh | output | 12 | One-hot current state |
| cpi_last | output | 4 | Cycle count of the last finished instruction |

## Verification
Two events can land on the same clock edge.

The first is in FETCH. The instruction read, the instruction register load and the PC increment all happen in one cycle. Instructions are issued back to back, so FETCH always directly follows the final state of the previous instruction. In that same cycle `cpi_last` must already show the previous instruction's length.

The second is in BEQ. The PC write there depends on `alu_zero` sampled in that cycle. The bench runs branches with the flag high and with it low. It checks that the PC write follows the flag in that cycle and that the state still returns to FETCH after three cycles.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int OPW    = 6;
    localparam int FNW    = 6;
    localparam int NSTATE = 12;
    localparam int SW     = $clog2(NSTATE);

    typedef enum logic [SW-1:0] {
        S_FETCH = 4'd0,  S_DECODE = 4'd1, S_EXE_R = 4'd2,  S_EXE_I = 4'd3,
        S_ADDR  = 4'd4,  S_MRD    = 4'd5, S_MWR   = 4'd6,  S_WB_R  = 4'd7,
        S_WB_I  = 4'd8,  S_WB_LD  = 4'd9, S_BEQ   = 4'd10, S_JMP   = 4'd11
    } state_t;

    typedef enum logic [2:0] {
        C_R, C_ORI, C_LW, C_SW, C_BEQ, C_J, C_BAD
    } cls_t;

    localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OP_ORI   = 6'h0D;
    localparam logic [OPW-1:0] OP_LW    = 6'h23;
    localparam logic [OPW-1:0] OP_SW    = 6'h2B;
    localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPW-1:0] OP_J     = 6'h02;

    localparam logic [FNW-1:0] FN_ADD = 6'h20;
    localparam logic [FNW-1:0] FN_SUB = 6'h22;
    localparam logic [FNW-1:0] FN_AND = 6'h24;
    localparam logic [FNW-1:0] FN_OR  = 6'h25;
    localparam logic [FNW-1:0] FN_SLT = 6'h2A;

    localparam logic [2:0] ALU_ADD = 3'd0;
    localparam logic [2:0] ALU_SUB = 3'd1;
    localparam logic [2:0] ALU_AND = 3'd2;
    localparam logic [2:0] ALU_OR  = 3'd3;
    localparam logic [2:0] ALU_SLT = 3'd4;

    localparam logic [2:0] BS_B     = 3'd0;
    localparam logic [2:0] BS_FOUR  = 3'd1;
    localparam logic [2:0] BS_SEXT  = 3'd2;
    localparam logic [2:0] BS_SEXT4 = 3'd3;
    localparam logic [2:0] BS_ZEXT  = 3'd4;

    localparam logic [1:0] PS_SEQ = 2'd0;
    localparam logic [1:0] PS_TGT = 2'd1;
    localparam logic [1:0] PS_JMP = 2'd2;

    typedef struct packed {
        logic       ir_wr;
        logic       pc_wr;
        logic [1:0] pc_src;
        logic       rf_wr;
        logic       rf_dst;
        logic       a_sel;
        logic [2:0] b_sel;
        logic [2:0] alu_op;
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       mem_to_reg;
        logic       ab_wr;
        logic       tgt_wr;
        logic       illegal;
    } ctl_t;
endpackage

// File: rtl/mcs_classify.sv
module mcs_classify
    import mcs_pkg::*;
#(
    parameter int OW = OPW,
    parameter int FW = FNW
) (
    input  logic [OW-1:0] opcode,
    input  logic [FW-1:0] funct,
    output cls_t          cls,
    output logic [2:0]    rop
);
    always_comb begin
        rop = ALU_ADD;
        cls = C_BAD;
        unique case (opcode)
            OP_RTYPE: begin
                cls = C_R;
                unique case (funct)
                    FN_ADD:  rop = ALU_ADD;
                    FN_SUB:  rop = ALU_SUB;
                    FN_AND:  rop = ALU_AND;
                    FN_OR:   rop = ALU_OR;
                    FN_SLT:  rop = ALU_SLT;
                    default: cls = C_BAD;
                endcase
            end
            OP_ORI:  cls = C_ORI;
            OP_LW:   cls = C_LW;
            OP_SW:   cls = C_SW;
            OP_BEQ:  cls = C_BEQ;
            OP_J:    cls = C_J;
            default: cls = C_BAD;
        endcase
    end
endmodule

// File: rtl/mcs_outs.sv
module mcs_outs
    import mcs_pkg::*;
(
    input  logic       rst,
    input  state_t     state,
    input  cls_t       cls,
    input  logic [2:0] rop,
    input  logic       alu_zero,
    output ctl_t       ctl
);
    always_comb begin
        ctl = '0;
        unique case (state)
            S_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_wr  = 1'b1;
                ctl.pc_wr  = 1'b1;
                ctl.b_sel  = BS_FOUR;
            end
            S_DECODE: begin
                ctl.ab_wr   = 1'b1;
                ctl.tgt_wr  = 1'b1;
                ctl.b_sel   = BS_SEXT4;
                ctl.illegal = (cls == C_BAD);
            end
            S_EXE_R: begin
                ctl.a_sel  = 1'b1;
                ctl.alu_op = rop;
            end
            S_EXE_I: begin
                ctl.a_sel  = 1'b1;
                ctl.b_sel  = BS_ZEXT;
                ctl.alu_op = ALU_OR;
            end
            S_ADDR: begin
                ctl.a_sel = 1'b1;
                ctl.b_sel = BS_SEXT;
            end
            S_MRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_MWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_WB_R: begin
                ctl.rf_wr  = 1'b1;
                ctl.rf_dst = 1'b1;
            end
            S_WB_I: ctl.rf_wr = 1'b1;
            S_WB_LD: begin
                ctl.rf_wr      = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            S_BEQ: begin
                ctl.a_sel  = 1'b1;
                ctl.alu_op = ALU_SUB;
                ctl.pc_src = PS_TGT;
                ctl.pc_wr  = alu_zero;
            end
            S_JMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PS_JMP;
            end
            default: ;
        endcase
        if (rst) begin
            ctl.ir_wr   = 1'b0;
            ctl.pc_wr   = 1'b0;
            ctl.rf_wr   = 1'b0;
            ctl.mem_rd  = 1'b0;
            ctl.mem_wr  = 1'b0;
            ctl.ab_wr   = 1'b0;
            ctl.tgt_wr  = 1'b0;
            ctl.illegal = 1'b0;
        end
    end
endmodule

// File: rtl/mcs_retire_cnt.sv
module mcs_retire_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          to_fetch,
    output logic [CW-1:0] cpi
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(1);
            cpi <= '0;
        end else if (to_fetch) begin
            cpi <= cnt;
            cnt <= CW'(1);
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mcs_ctl_seq.sv
module mcs_ctl_seq
    import mcs_pkg::*;
#(
    parameter int CNTW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPW-1:0]    opcode,
    input  logic [FNW-1:0]    funct,
    input  logic              alu_zero,
    output logic              ir_wr,
    output logic              pc_wr,
    output logic [1:0]        pc_src,
    output logic              rf_wr,
    output logic              rf_dst,
    output logic              alu_a_sel,
    output logic [2:0]        alu_b_sel,
    output logic [2:0]        alu_op,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_addr_sel,
    output logic              mem_to_reg,
    output logic              ab_wr,
    output logic              tgt_wr,
    output logic              illegal,
    output logic [NSTATE-1:0] state_oh,
    output logic [CNTW-1:0]   cpi_last
);
    state_t     state, nxt;
    cls_t       cls;
    logic [2:0] rop;
    ctl_t       ctl;

    mcs_classify #(.OW(OPW), .FW(FNW)) u_cls (
        .opcode(opcode), .funct(funct), .cls(cls), .rop(rop)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = S_FETCH;
        unique case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                unique case (cls)
                    C_R:     nxt = S_EXE_R;
                    C_ORI:   nxt = S_EXE_I;
                    C_LW:    nxt = S_ADDR;
                    C_SW:    nxt = S_ADDR;
                    C_BEQ:   nxt = S_BEQ;
                    C_J:     nxt = S_JMP;
                    default: nxt = S_FETCH;
                endcase
            end
            S_EXE_R:  nxt = S_WB_R;
            S_EXE_I:  nxt = S_WB_I;
            S_ADDR:   nxt = (cls == C_LW) ? S_MRD : S_MWR;
            S_MRD:    nxt = S_WB_LD;
            default:  nxt = S_FETCH;
        endcase
    end

    mcs_outs u_outs (
        .rst(rst), .state(state), .cls(cls), .rop(rop),
        .alu_zero(alu_zero), .ctl(ctl)
    );

    mcs_retire_cnt #(.CW(CNTW)) u_cnt (
        .clk(clk), .rst(rst), .to_fetch(nxt == S_FETCH), .cpi(cpi_last)
    );

    for (genvar g = 0; g < NSTATE; g++) begin : g_oh
        assign state_oh[g] = (SW'(state) == SW'(g));
    end

    assign ir_wr        = ctl.ir_wr;
    assign pc_wr        = ctl.pc_wr;
    assign pc_src       = ctl.pc_src;
    assign rf_wr        = ctl.rf_wr;
    assign rf_dst       = ctl.rf_dst;
    assign alu_a_sel    = ctl.a_sel;
    assign alu_b_sel    = ctl.b_sel;
    assign alu_op       = ctl.alu_op;
    assign mem_rd       = ctl.mem_rd;
    assign mem_wr       = ctl.mem_wr;
    assign mem_addr_sel = ctl.addr_sel;
    assign mem_to_reg   = ctl.mem_to_reg;
    assign ab_wr        = ctl.ab_wr;
    assign tgt_wr       = ctl.tgt_wr;
    assign illegal      = ctl.illegal;
endmodule

// File: rtl/mcs_ctl_seq_chk.sv
module mcs_ctl_seq_chk #(
    parameter int NS = 12,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ir_wr,
    input logic          pc_wr,
    input logic [1:0]    pc_src,
    input logic          rf_wr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          ab_wr,
    input logic          tgt_wr,
    input logic          alu_zero,
    input logic          illegal,
    input logic [NS-1:0] state_oh,
    input logic [CW-1:0] cpi_last
);
    // R1
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_in_reset_chk: assert (!(ir_wr | pc_wr | rf_wr | mem_rd | mem_wr | ab_wr | tgt_wr | illegal));
        end
    end

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_oh == NS'(1));

    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[0] |=> state_oh[1]);

    // R6
    load_read_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[5] |=> state_oh[9]);

    // R8
    branch_follows_zero_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[10] |-> (pc_wr == alu_zero) && (pc_src == 2'd1));

    // R9
    jump_loads_pc_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[11] |-> pc_wr && (pc_src == 2'd2));

    // R10
    illegal_returns_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> state_oh[0]);

    // R11
    single_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

    // R12
    load_counts_five_chk: assert property (@(posedge clk) disable iff (rst)
        state_oh[9] |=> cpi_last == CW'(5));

    // R13
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind mcs_ctl_seq mcs_ctl_seq_chk #(.NS(mcs_pkg::NSTATE), .CW(CNTW)) u_chk (.*);

// File: tb/tb_mcs_ctl_seq.sv
module tb_mcs_ctl_seq;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic        alu_zero = 1'b0;
    logic        ir_wr, pc_wr, rf_wr, rf_dst, alu_a_sel;
    logic [1:0]  pc_src;
    logic [2:0]  alu_b_sel, alu_op;
    logic        mem_rd, mem_wr, mem_addr_sel, mem_to_reg, ab_wr, tgt_wr, illegal;
    logic [11:0] state_oh;
    logic [3:0]  cpi_last;

    int total = 0;
    int bad = 0;
    int prev_len = 0;
    logic [32:0] exp_q[$];
    int          req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcs_ctl_seq dut (.*);

    // alu operation code for an R-type function field, -1 when not decoded (R4, R10)
    function automatic int fn_code(logic [5:0] fn);
        case (fn)
            6'h20:   return 0;
            6'h22:   return 1;
            6'h24:   return 2;
            6'h25:   return 3;
            6'h2A:   return 4;
            default: return -1;
        endcase
    endfunction

    // expected control word for one state, all unnamed fields 0 (R11)
    function automatic logic [32:0] exp_word(int st, logic [5:0] fn, logic z, logic bad_ins);
        logic ir, pw, rw, rd, as, mr, mw, ad, m2r, ab, tg, il;
        logic [1:0]  ps;
        logic [2:0]  bs, ao;
        logic [11:0] oh;
        {ir, pw, rw, rd, as, mr, mw, ad, m2r, ab, tg, il} = '0;
        ps = '0; bs = '0; ao = '0; oh = '0;
        oh[st] = 1'b1;
        case (st)
            0:  begin mr = 1; ir = 1; pw = 1; bs = 3'd1; end
            1:  begin ab = 1; tg = 1; bs = 3'd3; il = bad_ins; end
            2:  begin as = 1; ao = 3'(fn_code(fn)); end
            3:  begin as = 1; bs = 3'd4; ao = 3'd3; end
            4:  begin as = 1; bs = 3'd2; end
            5:  begin mr = 1; ad = 1; end
            6:  begin mw = 1; ad = 1; end
            7:  begin rw = 1; rd = 1; end
            8:  rw = 1;
            9:  begin rw = 1; m2r = 1; end
            10: begin as = 1; ao = 3'd1; ps = 2'd1; pw = z; end
            11: begin pw = 1; ps = 2'd2; end
            default: ;
        endcase
        return {ir, pw, ps, rw, rd, as, bs, ao, mr, mw, ad, m2r, ab, tg, il, oh};
    endfunction

    // monitor: compares each cycle with the scoreboard head
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [32:0] act, e;
            int r;
            act = {ir_wr, pc_wr, pc_src, rf_wr, rf_dst, alu_a_sel, alu_b_sel, alu_op,
                   mem_rd, mem_wr, mem_addr_sel, mem_to_reg, ab_wr, tgt_wr, illegal, state_oh};
            e = exp_q.pop_front();
            r = req_q.pop_front();
            total++;
            if (act !== e) begin
                bad++;
                $display("FAIL R%0d: actual=%h expected=%h", r, act, e);
            end
        end
    end

    // driver: called at the start of a FETCH cycle
    task automatic issue(input logic [5:0] op, input logic [5:0] fn, input logic z, input int req);
        int  path[$];
        logic bad_ins;
        bad_ins = 1'b0;
        case (op)
            6'h00: if (fn_code(fn) >= 0) path = '{0, 1, 2, 7}; else begin path = '{0, 1}; bad_ins = 1; end
            6'h0D: path = '{0, 1, 3, 8};
            6'h23: path = '{0, 1, 4, 5, 9};
            6'h2B: path = '{0, 1, 4, 6};
            6'h04: path = '{0, 1, 10};
            6'h02: path = '{0, 1, 11};
            default: begin path = '{0, 1}; bad_ins = 1; end
        endcase
        opcode = op; funct = fn; alu_zero = z;
        // R12: length of the previous instruction
        total++;
        if (cpi_last !== 4'(prev_len)) begin
            bad++;
            $display("FAIL R12: actual=%0d expected=%0d", cpi_last, prev_len);
        end
        foreach (path[i]) begin
            exp_q.push_back(exp_word(path[i], fn, z, bad_ins));
            req_q.push_back(req);
        end
        repeat (path.size()) @(posedge clk);
        #1;
        prev_len = path.size();
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state and quiet enables
        total++;
        if (state_oh !== 12'h001 || cpi_last !== 4'd0) begin
            bad++;
            $display("FAIL R1: actual=%h/%0d expected=001/0", state_oh, cpi_last);
        end
        total++;
        if ({ir_wr, pc_wr, rf_wr, mem_rd, mem_wr, ab_wr, tgt_wr, illegal} !== 8'h00) begin
            bad++;
            $display("FAIL R1: actual=%b expected=00000000",
                     {ir_wr, pc_wr, rf_wr, mem_rd, mem_wr, ab_wr, tgt_wr, illegal});
        end
        @(posedge clk); #1;
        rst = 1'b0;
        issue(6'h00, 6'h20, 1'b0, 4);  // R4 add, also R2 R3 R11 R13
        issue(6'h00, 6'h22, 1'b1, 4);  // R4 sub
        issue(6'h00, 6'h24, 1'b0, 4);  // R4 and
        issue(6'h00, 6'h25, 1'b0, 4);  // R4 or
        issue(6'h00, 6'h2A, 1'b0, 4);  // R4 slt
        issue(6'h0D, 6'h3F, 1'b0, 5);  // R5 OR-immediate
        issue(6'h23, 6'h00, 1'b0, 6);  // R6 load
        issue(6'h2B, 6'h00, 1'b0, 7);  // R7 store
        issue(6'h04, 6'h00, 1'b1, 8);  // R8 taken
        issue(6'h04, 6'h00, 1'b0, 8);  // R8 not taken
        issue(6'h02, 6'h00, 1'b1, 9);  // R9 jump
        issue(6'h3F, 6'h00, 1'b0, 10); // R10 unknown opcode
        issue(6'h00, 6'h01, 1'b0, 10); // R10 unknown function field
        issue(6'h23, 6'h00, 1'b1, 6);  // R6 load after illegal
        issue(6'h23, 6'h00, 1'b0, 6);  // R6 back-to-back load
        issue(6'h02, 6'h00, 1'b0, 12); // R12 jump after load
        issue(6'h00, 6'h20, 1'b0, 12); // R12 reports jump length
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule